// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the byte returned to the host on a read while the memory is busy with an embedded program or chip erase. A command controller reports that an operation is running, whether it is suspended, and whether it is a program or an erase. The controller also supplies the latched target address and the byte being programmed. On every read strobe the block registers one byte onto `rd_data`. That byte is either the array word the controller presents, or a status byte that holds a data-polling flag and a toggle flag.

The host polls the target location. While a program runs, the most significant bit reads back inverted from the byte being written. During a chip erase it reads 0. When the operation ends the controller drops `op_busy`, the block stops matching the target, and the array word comes through again. A host therefore sees its own data bit come back, or a 1 after an erase. The toggle flag changes on each status read while the operation runs, and it holds still during a suspend. A separate `ready` output goes low while an operation runs and returns high when the block is idle or suspended.

Top module: `op_status_flags`

## Requirements
- R1: After reset, `rd_valid` is 0, `rd_data` is all zeros and `ready` is 1.
- R2: A read strobe in cycle N makes `rd_valid` 1 in cycle N+1 only. When no status is selected, `rd_data` in cycle N+1 equals `arr_data` as sampled in cycle N.
- R3: While a program runs and is not suspended, a read at exactly `tgt_addr` returns bit DW-1 (polling flag) as the complement of `wr_data[DW-1]`.
- R4: While a chip erase runs and is not suspended, a read at any address returns the status byte, with bit DW-1 equal to 0.
- R5: Bit DW-2 of the status byte is the toggle flag. It reads 0 on the first status read after reset. It inverts on each later status read made while the operation is active and not suspended.
- R6: While suspended, a program status read at `tgt_addr` keeps the polling flag of R3 and returns the same toggle value on every read. A read at any other address returns array data. During an erase suspend, every address returns array data. After resume the toggle flag continues alternating from its held value.
- R7: During a program, a read at an address other than `tgt_addr` returns array data and does not advance the toggle flag.
- R8: Bits DW-3 down to 0 of every status byte read as 0.
- R9: `ready` is 0 in the cycle after `op_busy`=1 and `op_suspended`=0 are presented. Otherwise it is 1 in the following cycle.
- R10: Once `op_busy` is 0, a read at the former target address returns array data. A byte that was programmed correctly therefore shows its own bit DW-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_busy | input | 1 | Embedded operation in progress |
| op_suspended | input | 1 | Running operation is suspended |
| op_is_erase | input | 1 | 1 = chip erase, 0 = program |
| tgt_addr | input | AW | Latched program target address |
| wr_data | input | DW | Byte being programmed |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | AW | Read address |
| arr_data | input | DW | Array word for `rd_addr` |
| rd_data | output | DW | Registered read result |
| rd_valid | output | 1 | `rd_data` updated this cycle |
| ready | output | 1 | 0 while an operation runs unsuspended |

## Verification
The assertions check on every cycle the things that depend only on one cycle of inputs: the strobe-to-valid timing, the ready level, the polling polarity for program and erase, and the zero low bits. The toggle sequence relies on history, so the bench scenarios show it: alternation across reads, the freeze while suspended, off-target reads that leave it untouched, and continuation after resume. The bench scenarios also show that array data returns at the former target once the operation ends.

// File: rtl/osf_pkg.sv
package osf_pkg;
  // Position of the flag bits inside a DW-bit status byte.
  function automatic int poll_pos(input int dw);
    return dw - 1;
  endfunction

  function automatic int tog_pos(input int dw);
    return dw - 2;
  endfunction
endpackage

// File: rtl/osf_target_match.sv
module osf_target_match #(
  parameter int AW = 8
) (
  input  logic          op_busy,
  input  logic          op_suspended,
  input  logic          op_is_erase,
  input  logic [AW-1:0] tgt_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          status_sel,
  output logic          tog_adv_ok
);
  logic addr_hit;

  always_comb begin
    addr_hit   = (rd_addr == tgt_addr);
    status_sel = 1'b0;
    if (op_busy) begin
      if (op_is_erase) begin
        status_sel = !op_suspended;
      end else begin
        status_sel = addr_hit;
      end
    end
    tog_adv_ok = status_sel && !op_suspended;
  end
endmodule

// File: rtl/osf_toggle_gen.sv
module osf_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic adv_ok,
  output logic tog
);
  logic tog_q, tog_d, tog_en;

  always_comb begin
    tog_en = rd_stb && adv_ok;
    tog_d  = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (tog_en) begin
      tog_q <= tog_d;
    end
  end

  assign tog = tog_q;
endmodule

// File: rtl/osf_read_mux.sv
module osf_read_mux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          status_sel,
  input  logic          op_is_erase,
  input  logic          tog,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  import osf_pkg::*;
  localparam int PB = poll_pos(DW);
  localparam int TB = tog_pos(DW);

  logic [DW-1:0] stat_byte, data_d, data_q;
  logic          valid_q;

  always_comb begin
    stat_byte     = '0;
    stat_byte[PB] = op_is_erase ? 1'b0 : ~wr_data[PB];
    stat_byte[TB] = tog;
    data_d        = status_sel ? stat_byte : arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_stb;
      if (rd_stb) begin
        data_q <= data_d;
      end
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/op_status_flags.sv
module op_status_flags #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_busy,
  input  logic          op_suspended,
  input  logic          op_is_erase,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          ready
);
  logic status_sel, tog_adv_ok, tog;
  logic ready_d, ready_q;

  osf_target_match #(.AW(AW)) u_match (
    .op_busy(op_busy), .op_suspended(op_suspended), .op_is_erase(op_is_erase),
    .tgt_addr(tgt_addr), .rd_addr(rd_addr),
    .status_sel(status_sel), .tog_adv_ok(tog_adv_ok)
  );

  osf_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .adv_ok(tog_adv_ok), .tog(tog)
  );

  osf_read_mux #(.DW(DW)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .status_sel(status_sel),
    .op_is_erase(op_is_erase), .tog(tog), .wr_data(wr_data),
    .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_comb begin
    ready_d = !(op_busy && !op_suspended);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
    end else begin
      ready_q <= ready_d;
    end
  end

  assign ready = ready_q;
endmodule

// File: rtl/op_status_flags_chk.sv
module op_status_flags_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_busy,
  input logic          op_suspended,
  input logic          op_is_erase,
  input logic [AW-1:0] tgt_addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_stb,
  input logic [AW-1:0] rd_addr,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          ready
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_valid);
  a_r9_busy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !op_suspended) |=> !ready);
  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_busy && !op_suspended) |=> ready);
  a_r4_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_busy && op_is_erase && !op_suspended) |=> !rd_data[DW-1]);
  a_r3_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_busy && !op_is_erase && rd_addr == tgt_addr)
      |=> rd_data[DW-1] == !$past(wr_data[DW-1]));
  a_r8_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && op_busy && !op_is_erase && rd_addr == tgt_addr)
      |=> rd_data[DW-3:0] == '0);
endmodule

bind op_status_flags op_status_flags_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tb_op_status_flags.sv
module tb_op_status_flags;
  localparam int AW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_busy = 1'b0, op_suspended = 1'b0, op_is_erase = 1'b0;
  logic [AW-1:0] tgt_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, arr_data = '0;
  logic          rd_stb = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, ready;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  bit tog_m = 1'b0;

  always #4 clk = ~clk;

  op_status_flags #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
    return DW'(a) ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one read, compare after the registering edge.
  task automatic do_read(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    rd_stb = 1'b1; rd_addr = a; arr_data = arr_of(a);
    @(negedge clk);
    rd_stb = 1'b0;
    check(req, rd_data, exp);
    check({req, " valid"}, {7'd0, rd_valid}, 8'd1);
  endtask

  function automatic logic [DW-1:0] stat_prog(input logic [DW-1:0] wd, input bit t);
    return {~wd[DW-1], t, 6'd0};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 valid", {7'd0, rd_valid}, 8'd0);
    check("R1 data", rd_data, 8'd0);
    check("R1 ready", {7'd0, ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no strobe no valid", {7'd0, rd_valid}, 8'd0);

    // R2 idle sweep
    for (int a = 0; a < 256; a += 7) do_read("R2 idle", AW'(a), arr_of(AW'(a)));

    // Program sweep over every data byte: R3 R5 R7 R8 R9 R10
    for (int wd = 0; wd < 256; wd++) begin
      @(negedge clk);
      op_busy = 1'b1; op_is_erase = 1'b0; op_suspended = 1'b0;
      wr_data = DW'(wd); tgt_addr = AW'(wd) ^ 8'h33;
      @(negedge clk);
      check("R9 busy ready low", {7'd0, ready}, 8'd0);
      do_read("R3 R5 R8 status", tgt_addr, stat_prog(DW'(wd), tog_m));
      tog_m = ~tog_m;
      do_read("R7 off target", tgt_addr + 1'b1, arr_of(tgt_addr + 1'b1));
      do_read("R5 alternate", tgt_addr, stat_prog(DW'(wd), tog_m));
      tog_m = ~tog_m;
      op_busy = 1'b0;
      @(negedge clk);
      check("R9 idle ready high", {7'd0, ready}, 8'd1);
      do_read("R10 done array", tgt_addr, arr_of(tgt_addr));
    end

    // R6 program suspend and resume
    @(negedge clk);
    op_busy = 1'b1; wr_data = 8'h4C; tgt_addr = 8'h90;
    do_read("R6 pre", 8'h90, stat_prog(8'h4C, tog_m)); tog_m = ~tog_m;
    op_suspended = 1'b1;
    @(negedge clk);
    check("R9 suspend ready high", {7'd0, ready}, 8'd1);
    do_read("R6 frozen a", 8'h90, stat_prog(8'h4C, tog_m));
    do_read("R6 frozen b", 8'h90, stat_prog(8'h4C, tog_m));
    do_read("R6 other addr", 8'h12, arr_of(8'h12));
    op_suspended = 1'b0;
    do_read("R6 resume a", 8'h90, stat_prog(8'h4C, tog_m)); tog_m = ~tog_m;
    do_read("R6 resume b", 8'h90, stat_prog(8'h4C, tog_m)); tog_m = ~tog_m;

    // R4 chip erase at many addresses
    op_is_erase = 1'b1;
    for (int a = 0; a < 256; a += 29) begin
      do_read("R4 R5 erase", AW'(a), {1'b0, tog_m, 6'd0});
      tog_m = ~tog_m;
    end
    op_suspended = 1'b1;
    do_read("R6 erase suspend", 8'h21, arr_of(8'h21));
    op_suspended = 1'b0;
    do_read("R6 erase resume", 8'h21, {1'b0, tog_m, 6'd0}); tog_m = ~tog_m;
    op_busy = 1'b0;
    do_read("R10 erase done", 8'h21, arr_of(8'h21));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule